// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe (active high) and the program-store read strobe (active low) for the multiplexed external memory bus of an 8-bit controller. It runs on the oscillator clock. A phase counter splits each machine cycle into twelve oscillator periods, and the current phase is brought out as an index that the rest of the bus logic can use.

At the clock edge that starts a machine cycle, the block captures four per-cycle indicators:

- whether the cycle touches external data memory;
- whether it is a code-table read;
- whether the core is executing from external program memory;
- the address-latch disable control.

The captured values decide which strobe pulses appear during that cycle. In a normal cycle the address-latch strobe pulses twice, at one sixth of the oscillator rate. An external data access drops the second address-latch pulse and both read-strobe pulses. The disable control silences the address-latch strobe, except in data-move or code-table cycles. External execution overrides the disable control.

Top module: `xbus_strobe_gen`

## Requirements
- R1: `mc_phase` resets to 0, counts up by one per clock, and wraps from 11 back to 0.
- R2: While `rst` is high, `ale` is 0 and `psen_n` is 1. The first machine cycle after reset emits no strobes; strobes start at the first wrap of the phase counter.
- R3: Inputs are sampled only at the clock edge where `mc_phase` goes from 11 to 0. Changing them in the middle of a machine cycle has no effect on that cycle's strobes.
- R4: In a cycle with no data access, no disable and no external execution, `ale` is 1 during phases 0-1 and 6-7 and 0 in all other phases.
- R5: In a cycle with `xdata_cyc` set, `ale` is 1 only in phases 0-1 and stays 0 in phases 6-7.
- R6: With `ale_dis` set and `xdata_cyc`, `ctab_cyc` and `ext_exec` all clear, `ale` stays 0 for the whole cycle.
- R7: With `ale_dis` set and `ctab_cyc` set, `ale` still pulses in both halves of the cycle.
- R8: With `ext_exec` set, `ale_dis` has no effect on `ale`.
- R9: With `ext_exec` set and `xdata_cyc` clear, `psen_n` is 0 in phases 3-4 and 9-10 and 1 in all other phases.
- R10: In a cycle with `xdata_cyc` set, `psen_n` stays 1 for the whole cycle.
- R11: With `ext_exec` clear, `psen_n` stays 1.
- R12: `ale` high and `psen_n` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| xdata_cyc | input | 1 | The coming machine cycle accesses external data memory |
| ctab_cyc | input | 1 | The coming machine cycle is a code-table read |
| ext_exec | input | 1 | The core executes from external program memory |
| ale_dis | input | 1 | Address-latch strobe disable control |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| mc_phase | output | 4 | Oscillator period index within the machine cycle (0..11) |

## Verification
The hardest case to reach from the ports is an input change in the middle of a cycle. Such a change has to be shown to have no effect, which means the sampling edge must be pinned to the exact oscillator period where the phase wraps. The stimulus re-randomizes every input on every clock, so mid-cycle changes happen constantly. A directed sequence also waits for phase 11, latches a normal cycle, and then raises the disable control while the cycle is running. The bench then checks that the second address-latch pulse still appears.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  // Per-machine-cycle attributes captured at the cycle boundary
  typedef struct packed {
    logic valid;   // a real cycle has been captured since reset
    logic xdata;   // external data access
    logic ctab;    // code-table read
    logic xexec;   // executing from external program memory
    logic aledis;  // address-latch disable control
  } cyc_flags_t;

  // Next phase value with wrap
  function automatic int phase_after(input int p, input int last);
    return (p >= last) ? 0 : p + 1;
  endfunction

  // True when phase p lies inside [ofs, ofs+w)
  function automatic logic in_slot(input int p, input int ofs, input int w);
    return (p >= ofs) && (p < ofs + w);
  endfunction

  // Is the address-latch pulse of half h permitted in this cycle
  function automatic logic ale_half_ok(input cyc_flags_t f, input int h);
    logic gate_open;
    gate_open = !f.aledis || f.xexec || f.xdata || f.ctab;
    return f.valid && gate_open && !(h == 1 && f.xdata);
  endfunction

  // Is the program-store read permitted in this cycle
  function automatic logic psen_ok(input cyc_flags_t f);
    return f.valid && f.xexec && !f.xdata;
  endfunction

endpackage

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
  parameter int CYC_LEN = 12,
  localparam int PW = $clog2(CYC_LEN),
  localparam int LAST = CYC_LEN - 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic          wrap
);
  import xbs_pkg::*;

  assign wrap = (int'(phase) == LAST);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= PW'(phase_after(int'(phase), LAST));
  end

  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(phase) <= LAST);

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !$past(rst)) |=> (phase == $past(phase) + 1'b1));

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == '0));

endmodule

// File: rtl/xbs_cycle_latch.sv
module xbs_cycle_latch (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrap,
  input  logic                xdata_in,
  input  logic                ctab_in,
  input  logic                xexec_in,
  input  logic                aledis_in,
  output xbs_pkg::cyc_flags_t flags
);
  import xbs_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (wrap) begin
      flags.valid  <= 1'b1;
      flags.xdata  <= xdata_in;
      flags.ctab   <= ctab_in;
      flags.xexec  <= xexec_in;
      flags.aledis <= aledis_in;
    end
  end

  // R3
  mid_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(flags));

endmodule

// File: rtl/xbs_strobe_dec.sv
module xbs_strobe_dec #(
  parameter int CYC_LEN = 12,
  parameter int STRB_W = 2,
  parameter int ALE_OFS = 0,
  parameter int PSEN_OFS = 3,
  localparam int PW = $clog2(CYC_LEN),
  localparam int HALF = CYC_LEN / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PW-1:0]       phase,
  input  xbs_pkg::cyc_flags_t flags,
  output logic [1:0]          ale_slot,
  output logic [1:0]          psen_slot
);
  import xbs_pkg::*;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int BASE = h * HALF;
    assign ale_slot[h]  = in_slot(int'(phase), BASE + ALE_OFS, STRB_W)
                          && ale_half_ok(flags, h);
    assign psen_slot[h] = in_slot(int'(phase), BASE + PSEN_OFS, STRB_W)
                          && psen_ok(flags);
  end

  // R5
  xdata_second_ale_chk: assert property (@(posedge clk) disable iff (rst)
    flags.xdata |-> !ale_slot[1]);

  // R10
  xdata_no_psen_chk: assert property (@(posedge clk) disable iff (rst)
    flags.xdata |-> (psen_slot == 2'b00));

  // R11
  psen_needs_exec_chk: assert property (@(posedge clk) disable iff (rst)
    (psen_slot != 2'b00) |-> flags.xexec);

  // R6
  ale_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (flags.aledis && !flags.xexec && !flags.xdata && !flags.ctab)
      |-> (ale_slot == 2'b00));

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
  parameter int CYC_LEN = 12,
  parameter int STRB_W = 2,
  parameter int ALE_OFS = 0,
  parameter int PSEN_OFS = 3,
  localparam int PW = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xdata_cyc,
  input  logic          ctab_cyc,
  input  logic          ext_exec,
  input  logic          ale_dis,
  output logic          ale,
  output logic          psen_n,
  output logic [PW-1:0] mc_phase
);
  import xbs_pkg::*;

  logic       wrap;
  cyc_flags_t cur_flags;
  logic [1:0] ale_slot;
  logic [1:0] psen_slot;

  xbs_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (mc_phase),
    .wrap  (wrap)
  );

  xbs_cycle_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .xdata_in  (xdata_cyc),
    .ctab_in   (ctab_cyc),
    .xexec_in  (ext_exec),
    .aledis_in (ale_dis),
    .flags     (cur_flags)
  );

  xbs_strobe_dec #(
    .CYC_LEN  (CYC_LEN),
    .STRB_W   (STRB_W),
    .ALE_OFS  (ALE_OFS),
    .PSEN_OFS (PSEN_OFS)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .phase     (mc_phase),
    .flags     (cur_flags),
    .ale_slot  (ale_slot),
    .psen_slot (psen_slot)
  );

  assign ale    = |ale_slot;
  assign psen_n = ~|psen_slot;

  // R12
  strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  // R2
  dormant_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cur_flags.valid |-> (!ale && psen_n));

endmodule

// File: tb/xbus_strobe_gen_bench.sv
module xbus_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xdata_cyc = 1'b0, ctab_cyc = 1'b0, ext_exec = 1'b0, ale_dis = 1'b0;
  logic ale, psen_n;
  logic [3:0] mc_phase;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_ph = 0;
  bit m_v = 0, m_xd = 0, m_ct = 0, m_xe = 0, m_ds = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_strobe_gen u_xbus_strobe_gen (
    .clk(clk), .rst(rst), .xdata_cyc(xdata_cyc), .ctab_cyc(ctab_cyc),
    .ext_exec(ext_exec), .ale_dis(ale_dis), .ale(ale), .psen_n(psen_n),
    .mc_phase(mc_phase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (phase %0d)", tag, act, exp, m_ph);
    end
  endtask

  function automatic bit exp_ale(input int ph);
    bit first, second;
    if (!m_v) return 0;
    first  = !m_ds || m_xe || m_xd || m_ct;
    second = first && !m_xd;
    return ((ph == 0 || ph == 1) && first) || ((ph == 6 || ph == 7) && second);
  endfunction

  function automatic bit exp_psen_n(input int ph);
    if (!m_v || !m_xe || m_xd) return 1;
    return !(ph == 3 || ph == 4 || ph == 9 || ph == 10);
  endfunction

  function automatic string ale_tag();
    if (!m_v) return "R2";
    if (m_xd) return "R5";
    if (m_xe && m_ds) return "R8";
    if (m_ds && m_ct) return "R7";
    if (m_ds) return "R6";
    return "R4";
  endfunction

  function automatic string psen_tag();
    if (!m_v) return "R2";
    if (m_xd) return "R10";
    if (m_xe) return "R9";
    return "R11";
  endfunction

  // one clock: drive, update model at the edge, compare at negedge
  task automatic step(input bit xd, input bit ct, input bit xe, input bit ds);
    bit ea, ep;
    xdata_cyc = xd; ctab_cyc = ct; ext_exec = xe; ale_dis = ds;
    @(posedge clk);
    if (rst) begin
      m_ph = 0; m_v = 0;
    end else begin
      if (m_ph == 11) begin
        m_v = 1; m_xd = xd; m_ct = ct; m_xe = xe; m_ds = ds;
      end
      m_ph = (m_ph == 11) ? 0 : m_ph + 1;
    end
    @(negedge clk);
    ea = exp_ale(m_ph);
    ep = exp_psen_n(m_ph);
    chk(int'(mc_phase) == m_ph, "R1", int'(mc_phase), m_ph);
    chk(ale == ea, ale_tag(), int'(ale), int'(ea));
    chk(psen_n == ep, psen_tag(), int'(psen_n), int'(ep));
    chk(!(ale && !psen_n), "R12", int'(ale), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R2: reset holds strobes inactive
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0);
      chk(ale == 1'b0 && psen_n == 1'b1, "R2", int'({ale, psen_n}), 1);
    end
    rst = 1'b0;
    // directed: normal, external exec, xdata, disable, ctab under disable
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b0, 1'b0);  // R4
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b1, 1'b0);  // R9
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 1'b1, 1'b0);  // R5 R10
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b0, 1'b1);  // R6
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b0, 1'b1);  // R7
    for (int i = 0; i < 24; i++) step(1'b0, 1'b0, 1'b1, 1'b1);  // R8
    // R3: latch a normal cycle, then raise the disable mid-cycle
    while (m_ph != 11) step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    while (m_ph != 6) step(1'b1, 1'b0, 1'b0, 1'b1);
    chk(ale == 1'b1, "R3", int'(ale), 1);
    // random mix with inputs changing every clock
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 3) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    // R2: reset in the middle of a cycle
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk(ale == 1'b0 && psen_n == 1'b1 && mc_phase == 4'd0, "R2",
        int'({ale, psen_n}), 1);
    rst = 1'b0;
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule